// File: doc/BRIEF.md
# GPIO Pin Multiplexer with Coprocessor Routing

This block sits between the core logic and the pad ring of a chip with several GPIO banks of unequal size. Each pin owns a 3-bit route code in a register file. Codes 0 to 3 attach the pin to one of four ordinary peripheral functions. Codes 4 to 7 hand the whole pin to one of four small bit-banging I/O coprocessors. Output value and output enable go to the pad, and the pad input value comes back to whichever function or coprocessor owns the pin. All of this logic runs in the core voltage domain. Level translation happens beyond the pad outputs.

Every coprocessor has a 28-line GPIO port, and each line can raise an interrupt. Pins are numbered across the banks in the order A, B, C, D, E, F. A fixed table folds every pin onto a coprocessor line number. The middle banks map pin n straight to line n. The two short banks share one port: bank A fills lines 0 to 15 and bank F fills lines 16 to 25. Two pins can land on the same coprocessor line while that line drives. The block detects this and reports it on a per-coprocessor clash output.

Software programs the route codes through a 32-bit word port. Each word holds ten 3-bit fields. All routing results are registered, so they appear one clock after their inputs.

Top module: `gpio_pin_router`

## Requirements
- R1: While `rst` is high, every route code clears to 0 and `pad_oe` and `reg_rdata` are all zero on the clock that follows.
- R2: Word w of the register port holds the route code of pin 10*w+k in bits [3k+2:3k]. `reg_rdata` shows the word at `reg_addr` one clock after the address is presented. Bits 31:30, fields of pins that do not exist, and words past the last pin always read 0. Writes to any of these have no effect.
- R3: When a pin has code f (0 to 3), `pad_out` and `pad_oe` for that pin take the values of `fn_out[f]` and `fn_oe[f]` for that pin one clock later. The other functions have no effect on the pad.
- R4: When a pin has code 4+c, `pad_out` and `pad_oe` for that pin take the values of `cp_out[c]` and `cp_oe[c]` at the pin's mapped line one clock later.
- R5: The global pin order is A0-A15 = 0-15, B0-B27 = 16-43, C0-C23 = 44-67, D0-D23 = 68-91, E0-E23 = 92-115 and F0-F9 = 116-125. Banks B to E map pin n to line n. Bank A maps pin n to line n. Bank F maps pin n to line 16+n.
- R6: `fn_in[f]` for a pin carries that pin's `pad_in` one clock later when the pin has code f. Otherwise it reads 0.
- R7: `cp_in[c]` at line i carries, one clock later, the `pad_in` of a pin with code 4+c mapped to line i. This holds whatever `cp_oe` is. Lines that no pin selects read 0.
- R8: `cp_clash[c]` goes high one clock after two or more pins with code 4+c share a line whose `cp_oe[c]` bit is set. Among such pins, `cp_in` carries the input of the lowest-numbered one.
- R9: Pins that share a coprocessor line while its `cp_oe` bit is clear do not raise `cp_clash`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register word write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the addressed word |
| fn_out | input | 4 x NPIN | Output value per peripheral function per pin |
| fn_oe | input | 4 x NPIN | Output enable per peripheral function per pin |
| fn_in | output | 4 x NPIN | Pad input returned to the owning function |
| cp_out | input | 4 x COP_W | Coprocessor GPIO output values |
| cp_oe | input | 4 x COP_W | Coprocessor GPIO output enables |
| cp_in | output | 4 x COP_W | Pad input returned to coprocessor lines |
| cp_clash | output | 4 | Shared driven line detected, per coprocessor |
| pad_in | input | NPIN | Input value from each pad |
| pad_out | output | NPIN | Output value to each pad |
| pad_oe | output | NPIN | Output enable to each pad |

## Verification
The bench builds the block with its default parameters: six banks of 16, 28, 24, 24, 24 and 10 pins, with a line base of 16 for bank F. This covers a pin in every kind of bank, including both halves of the shared A/F port. The thirteenth register word is only partly filled, which exercises the read-as-zero fields for pins that do not exist. The default layout also allows two real clash cases, B7 with C7 and B16 with F0. In each case the lower-numbered pin must win, and the clash output must depend on the coprocessor's drive enable.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  // Route code: bit 2 picks coprocessor side, bits 1:0 pick which one.
  localparam int SEL_W           = 3;
  localparam int ROUTES          = 4;
  localparam int FIELDS_PER_WORD = 10;
  localparam int WORD_W          = 32;

  typedef logic [SEL_W-1:0] pin_sel_t;

  function automatic logic sel_is_cop(input pin_sel_t s);
    return s[SEL_W-1];
  endfunction

  function automatic logic [1:0] sel_route(input pin_sel_t s);
    return s[1:0];
  endfunction
endpackage

// File: rtl/pmx_sel_regs.sv
module pmx_sel_regs
  import pmx_pkg::*;
#(
  parameter int NPIN   = 126,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     rdata,
  output pin_sel_t [NPIN-1:0]   sel
);
  localparam int USED_W = SEL_W * FIELDS_PER_WORD;

  logic [WORD_W-1:0] rd_word;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[WORD_W-1:USED_W];

  // Field k of word w belongs to pin w*FIELDS_PER_WORD+k; absent pins have no storage.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (we) begin
      for (int p = 0; p < NPIN; p++) begin
        if (addr == ADDR_W'(p / FIELDS_PER_WORD))
          sel[p] <= wdata[SEL_W*(p % FIELDS_PER_WORD) +: SEL_W];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (addr == ADDR_W'(p / FIELDS_PER_WORD))
        rd_word[SEL_W*(p % FIELDS_PER_WORD) +: SEL_W] = sel[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_wr_chk
    AST_WR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (we && addr == ADDR_W'(p / FIELDS_PER_WORD)) |=>
        (sel[p] == $past(wdata[SEL_W*(p % FIELDS_PER_WORD) +: SEL_W]))); // R2
  end
endmodule

// File: rtl/pmx_pad_drive.sv
module pmx_pad_drive
  import pmx_pkg::*;
#(
  parameter int NPIN  = 126,
  parameter int COP_W = 28,
  parameter int IDX_W = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pin_sel_t [NPIN-1:0]           sel,
  input  logic [NPIN-1:0][IDX_W-1:0]    pin_idx,
  input  logic [ROUTES-1:0][NPIN-1:0]   fn_out,
  input  logic [ROUTES-1:0][NPIN-1:0]   fn_oe,
  input  logic [ROUTES-1:0][COP_W-1:0]  cp_out,
  input  logic [ROUTES-1:0][COP_W-1:0]  cp_oe,
  output logic [NPIN-1:0]               pad_out,
  output logic [NPIN-1:0]               pad_oe
);
  logic [NPIN-1:0] drv_out, drv_oe;

  always_comb begin
    drv_out = '0;
    drv_oe  = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (sel_is_cop(sel[p])) begin
        drv_out[p] = cp_out[sel_route(sel[p])][pin_idx[p]];
        drv_oe[p]  = cp_oe[sel_route(sel[p])][pin_idx[p]];
      end else begin
        drv_out[p] = fn_out[sel_route(sel[p])][p];
        drv_oe[p]  = fn_oe[sel_route(sel[p])][p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= drv_out;
      pad_oe  <= drv_oe;
    end
  end

  AST_OE_RESET: assert property (@(posedge clk) rst |=> (pad_oe == '0)); // R1

  for (genvar p = 0; p < NPIN; p++) begin : g_cop_chk
    AST_COP_OE_OFF: assert property (@(posedge clk) disable iff (rst)
      (sel_is_cop(sel[p]) && !cp_oe[sel_route(sel[p])][pin_idx[p]]) |=> !pad_oe[p]); // R4
  end
endmodule

// File: rtl/pmx_return_path.sv
module pmx_return_path
  import pmx_pkg::*;
#(
  parameter int NPIN  = 126,
  parameter int COP_W = 28,
  parameter int IDX_W = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pin_sel_t [NPIN-1:0]           sel,
  input  logic [NPIN-1:0][IDX_W-1:0]    pin_idx,
  input  logic [NPIN-1:0]               pad_in,
  input  logic [ROUTES-1:0][COP_W-1:0]  cp_oe,
  output logic [ROUTES-1:0][NPIN-1:0]   fn_in,
  output logic [ROUTES-1:0][COP_W-1:0]  cp_in,
  output logic [ROUTES-1:0]             cp_clash
);
  logic [ROUTES-1:0][NPIN-1:0]  fn_in_d;
  logic [ROUTES-1:0][COP_W-1:0] cp_in_d, seen, dup;
  logic [ROUTES-1:0]            clash_d;

  // Ascending scan: the first (lowest-numbered) claimant of a line wins,
  // any later claimant marks the line as shared.
  always_comb begin
    fn_in_d = '0;
    cp_in_d = '0;
    seen    = '0;
    dup     = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (sel_is_cop(sel[p])) begin
        if (seen[sel_route(sel[p])][pin_idx[p]]) begin
          dup[sel_route(sel[p])][pin_idx[p]] = 1'b1;
        end else begin
          seen[sel_route(sel[p])][pin_idx[p]]    = 1'b1;
          cp_in_d[sel_route(sel[p])][pin_idx[p]] = pad_in[p];
        end
      end else begin
        fn_in_d[sel_route(sel[p])][p] = pad_in[p];
      end
    end
    for (int c = 0; c < ROUTES; c++)
      clash_d[c] = |(dup[c] & cp_oe[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_in    <= '0;
      cp_in    <= '0;
      cp_clash <= '0;
    end else begin
      fn_in    <= fn_in_d;
      cp_in    <= cp_in_d;
      cp_clash <= clash_d;
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_fn_chk
    AST_FN_IN_QUIET: assert property (@(posedge clk) disable iff (rst)
      sel_is_cop(sel[p]) |=>
        !(fn_in[0][p] || fn_in[1][p] || fn_in[2][p] || fn_in[3][p])); // R6
  end

  for (genvar c = 0; c < ROUTES; c++) begin : g_clash_chk
    AST_CLASH_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
      cp_clash[c] |-> ($past(cp_oe[c]) != '0)); // R8
  end
endmodule

// File: rtl/gpio_pin_router.sv
module gpio_pin_router
  import pmx_pkg::*;
#(
  parameter int NBANK               = 6,
  parameter int BANK_PINS   [NBANK] = '{16, 28, 24, 24, 24, 10},
  parameter int BANK_LINE0  [NBANK] = '{0, 0, 0, 0, 0, 16},
  parameter int NPIN                = 126,
  parameter int COP_W               = 28,
  parameter int ADDR_W              = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_we,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [WORD_W-1:0]             reg_wdata,
  output logic [WORD_W-1:0]             reg_rdata,
  input  logic [ROUTES-1:0][NPIN-1:0]   fn_out,
  input  logic [ROUTES-1:0][NPIN-1:0]   fn_oe,
  output logic [ROUTES-1:0][NPIN-1:0]   fn_in,
  input  logic [ROUTES-1:0][COP_W-1:0]  cp_out,
  input  logic [ROUTES-1:0][COP_W-1:0]  cp_oe,
  output logic [ROUTES-1:0][COP_W-1:0]  cp_in,
  output logic [ROUTES-1:0]             cp_clash,
  input  logic [NPIN-1:0]               pad_in,
  output logic [NPIN-1:0]               pad_out,
  output logic [NPIN-1:0]               pad_oe
);
  localparam int IDX_W = $clog2(COP_W);

  function automatic int bank_total();
    int s = 0;
    for (int b = 0; b < NBANK; b++) s += BANK_PINS[b];
    return s;
  endfunction

  // Coprocessor line for a global pin number (banks concatenated in order).
  function automatic int line_of_pin(input int pin);
    int base = 0;
    int r    = 0;
    for (int b = 0; b < NBANK; b++) begin
      if (pin >= base && pin < base + BANK_PINS[b])
        r = BANK_LINE0[b] + pin - base;
      base += BANK_PINS[b];
    end
    return r;
  endfunction

  function automatic int max_line();
    int m = 0;
    for (int p = 0; p < NPIN; p++)
      if (line_of_pin(p) > m) m = line_of_pin(p);
    return m;
  endfunction

  logic [NPIN-1:0][IDX_W-1:0] pin_idx;
  pin_sel_t [NPIN-1:0]        sel;

  for (genvar p = 0; p < NPIN; p++) begin : g_map
    assign pin_idx[p] = IDX_W'(line_of_pin(p));
  end

  pmx_sel_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .sel   (sel)
  );

  pmx_pad_drive #(.NPIN(NPIN), .COP_W(COP_W), .IDX_W(IDX_W)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .pin_idx (pin_idx),
    .fn_out  (fn_out),
    .fn_oe   (fn_oe),
    .cp_out  (cp_out),
    .cp_oe   (cp_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  pmx_return_path #(.NPIN(NPIN), .COP_W(COP_W), .IDX_W(IDX_W)) u_ret (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .pin_idx  (pin_idx),
    .pad_in   (pad_in),
    .cp_oe    (cp_oe),
    .fn_in    (fn_in),
    .cp_in    (cp_in),
    .cp_clash (cp_clash)
  );

  initial begin
    AST_PIN_SUM: assert (bank_total() == NPIN); // R5
    AST_LINE_FITS: assert (max_line() < COP_W); // R5
  end
endmodule

// File: tb/tb_gpio_pin_router.sv
`timescale 1ns/1ps
module tb_gpio_pin_router;
  localparam int NPIN = 126;
  localparam int CW   = 28;
  localparam int K_OUT = 0, K_OE = 1, K_FNIN = 2, K_CPIN = 3, K_CLASH = 4,
                 K_RDATA = 5, K_OEANY = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0][NPIN-1:0] fn_out = '0, fn_oe = '0, fn_in;
  logic [3:0][CW-1:0] cp_out = '0, cp_oe = '0, cp_in;
  logic [3:0] cp_clash;
  logic [NPIN-1:0] pad_in = '0, pad_out, pad_oe;

  gpio_pin_router dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
    .cp_out(cp_out), .cp_oe(cp_oe), .cp_in(cp_in), .cp_clash(cp_clash),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          due;
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sbq[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  logic [2:0] shadow [NPIN];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] actual(input int kind, input int idx);
    case (kind)
      K_OUT:   return {31'd0, pad_out[idx]};
      K_OE:    return {31'd0, pad_oe[idx]};
      K_FNIN:  return {31'd0, fn_in[idx / NPIN][idx % NPIN]};
      K_CPIN:  return {31'd0, cp_in[idx / CW][idx % CW]};
      K_CLASH: return {31'd0, cp_clash[idx]};
      K_RDATA: return reg_rdata;
      default: return {31'd0, |pad_oe};
    endcase
  endfunction

  // Monitor: pops every item due this cycle and compares.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      logic [31:0] a;
      it = sbq.pop_front();
      checks++;
      a = actual(it.kind, it.idx);
      if (it.due != cyc || a !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d idx %0d actual %0h expected %0h (due %0d at %0d)",
                 it.req, it.kind, it.idx, a, it.exp, it.due, cyc);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_next(input int kind, input int idx, input logic [31:0] exp, input string req);
    item_t it;
    it.due = cyc + 1; it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic write_word(input int w, input logic [31:0] d);
    for (int k = 0; k < 10; k++)
      if (w*10 + k < NPIN) shadow[w*10 + k] = d[3*k +: 3];
    reg_we = 1'b1; reg_addr = 4'(w); reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic set_sel(input int p, input logic [2:0] code);
    logic [31:0] d;
    int w;
    shadow[p] = code;
    w = p / 10;
    d = '0;
    for (int k = 0; k < 10; k++)
      if (w*10 + k < NPIN) d[3*k +: 3] = shadow[w*10 + k];
    write_word(w, d);
  endtask

  initial begin
    for (int p = 0; p < NPIN; p++) shadow[p] = '0;
    fn_oe = '1;
    repeat (2) tick();
    // R1: reset state with drivers requesting enable everywhere
    expect_next(K_OEANY, 0, 32'd0, "R1");
    expect_next(K_RDATA, 0, 32'd0, "R1");
    tick();
    rst = 1'b0;
    fn_oe = '0;
    reg_addr = 4'd0;
    expect_next(K_RDATA, 0, 32'd0, "R1");
    tick();

    // R2: field packing, reserved bits, absent pins and words
    write_word(1, 32'hC000_00D1);
    reg_addr = 4'd1;
    expect_next(K_RDATA, 0, 32'h0000_00D1, "R2");
    tick();
    write_word(12, 32'hFFFF_FFFF);
    reg_addr = 4'd12;
    expect_next(K_RDATA, 0, 32'h0003_FFFF, "R2");
    tick();
    write_word(13, 32'hFFFF_FFFF);
    reg_addr = 4'd13;
    expect_next(K_RDATA, 0, 32'd0, "R2");
    tick();
    reg_addr = 4'd15;
    expect_next(K_RDATA, 0, 32'd0, "R2");
    tick();
    write_word(12, 32'd0);

    // R3 / R6: pins 10,11,12 hold codes 1,2,3; pin 0 holds code 0
    fn_out[1][10] = 1'b1; fn_oe[1][10] = 1'b1;
    fn_out[2][11] = 1'b0; fn_oe[2][11] = 1'b1; fn_out[0][11] = 1'b1;
    fn_oe[3][12] = 1'b0;  fn_oe[0][12] = 1'b1;
    fn_out[0][0] = 1'b1;  fn_oe[0][0] = 1'b1;
    pad_in[10] = 1'b1; pad_in[11] = 1'b1;
    expect_next(K_OUT, 10, 1, "R3");
    expect_next(K_OE, 10, 1, "R3");
    expect_next(K_OUT, 11, 0, "R3");
    expect_next(K_OE, 11, 1, "R3");
    expect_next(K_OE, 12, 0, "R3");
    expect_next(K_OUT, 0, 1, "R3");
    expect_next(K_FNIN, 2*NPIN + 11, 1, "R6");
    expect_next(K_FNIN, 0*NPIN + 11, 0, "R6");
    expect_next(K_FNIN, 1*NPIN + 10, 1, "R6");
    expect_next(K_FNIN, 2*NPIN + 10, 0, "R6");
    tick();

    // R4 / R5 / R7: B4 -> cop1 line 4, F3 -> cop3 line 19, A5 -> cop2 line 5, C6 -> cop0 line 6
    set_sel(20, 3'd5);
    set_sel(119, 3'd7);
    set_sel(5, 3'd6);
    set_sel(50, 3'd4);
    cp_out[1][4] = 1'b1;  cp_oe[1][4] = 1'b1; cp_out[0][4] = 1'b0;
    cp_out[3][19] = 1'b1; cp_oe[3][19] = 1'b0;
    cp_out[2][5] = 1'b1;  cp_oe[2][5] = 1'b1;
    cp_out[0][6] = 1'b1;  cp_oe[0][6] = 1'b1;
    pad_in[20] = 1'b1; pad_in[119] = 1'b1; pad_in[6] = 1'b1;
    expect_next(K_OUT, 20, 1, "R4");
    expect_next(K_OE, 20, 1, "R4");
    expect_next(K_OUT, 119, 1, "R5");
    expect_next(K_OE, 119, 0, "R4");
    expect_next(K_OUT, 5, 1, "R5");
    expect_next(K_OUT, 50, 1, "R5");
    expect_next(K_CPIN, 1*CW + 4, 1, "R7");
    expect_next(K_CPIN, 3*CW + 19, 1, "R7");
    expect_next(K_CPIN, 3*CW + 3, 0, "R7");
    expect_next(K_CPIN, 2*CW + 6, 0, "R7");
    expect_next(K_FNIN, 1*NPIN + 20, 0, "R6");
    expect_next(K_CLASH, 0, 0, "R9");
    tick();

    // R8: B7 and C7 both on cop0 line 7, driven
    set_sel(23, 3'd4);
    set_sel(51, 3'd4);
    cp_out[0][7] = 1'b1; cp_oe[0][7] = 1'b1;
    pad_in[23] = 1'b0; pad_in[51] = 1'b1;
    expect_next(K_CLASH, 0, 1, "R8");
    expect_next(K_CLASH, 1, 0, "R8");
    expect_next(K_CPIN, 0*CW + 7, 0, "R8");
    expect_next(K_OUT, 23, 1, "R4");
    expect_next(K_OUT, 51, 1, "R4");
    tick();
    pad_in[23] = 1'b1; pad_in[51] = 1'b0;
    expect_next(K_CPIN, 0*CW + 7, 1, "R8");
    tick();
    // R9: same sharing, drive released
    cp_oe[0][7] = 1'b0;
    expect_next(K_CLASH, 0, 0, "R9");
    expect_next(K_CPIN, 0*CW + 7, 1, "R7");
    tick();

    // R8 across the shared A/F port: B16 and F0 both on cop2 line 16
    set_sel(32, 3'd6);
    set_sel(116, 3'd6);
    cp_oe[2][16] = 1'b1;
    pad_in[32] = 1'b0; pad_in[116] = 1'b1;
    expect_next(K_CLASH, 2, 1, "R8");
    expect_next(K_CPIN, 2*CW + 16, 0, "R8");
    expect_next(K_CLASH, 0, 0, "R9");
    tick();

    repeat (3) tick();
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R1 scoreboard actual %0d pending expected 0", sbq.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule